// File: doc/BRIEF.md
# Float-to-Integer Conversion Unit with Selectable Rounding

This unit turns an IEEE-style binary floating-point operand, either a 32-bit single or a 64-bit double, into a two's-complement integer. The integer is either 32 bits wide (word) or 64 bits wide (long). A controller raises `start_i` for one cycle with the operand and the format selects. Exactly two clock edges later the unit pulses `done_o`. At the same moment it presents the converted value and three exception indications. Those outputs hold until the next conversion completes.

Rounding follows a two-bit mode. By default the mode comes from a global control field. When the per-operation override is marked valid, the override mode applies to that conversion instead. Some operands are never converted: denormals, signaling NaNs, quiet NaNs, infinities and values too large for the destination. For these the unit leaves the integer result register untouched and reports an unimplemented operation. Cases that are defined but cannot be represented also raise invalid.

Top module: `f2i_conv`

## Requirements
- R1: A conversion started by `start_i` high at clock edge k gives `done_o` high after edge k+2 for exactly one cycle. Back-to-back starts give back-to-back done pulses in start order.
- R2: The mode is `ovr_mode_i` when `ovr_valid_i` is 1 and `glob_mode_i` otherwise. The encoding is 0 = nearest, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.
- R3: `src_dbl_i` = 0 reads a single from `operand_i[31:0]`: sign in bit 31, biased-127 exponent in bits 30..23, mantissa in bits 22..0. The upper 32 operand bits are then ignored. `src_dbl_i` = 1 reads a double: sign in bit 63, biased-1023 exponent in bits 62..52, mantissa in bits 51..0. With `dst_long_i` = 0 the 32-bit result is sign-extended onto all 64 bits of `result_o`.
- R4: Directed modes follow these examples. Toward zero gives 4.9 -> 4 and -4.9 -> -4. Toward -infinity gives -4.9 -> -5 and -0.3 -> -1. Toward +infinity gives 4.1 -> 5, -4.1 -> -4 and 0.3 -> 1.
- R5: Nearest mode rounds to the closer integer (4.4 -> 4, 4.6 -> 5). Exact halves go to the even integer (2.5 -> 2, 3.5 -> 4, -2.5 -> -2, 5.5 -> 6).
- R6: `inexact_o` is 1 exactly when a converted value lost nonzero fraction bits. It is never 1 together with `unimpl_o`.
- R7: +0 and -0 convert to 0 with all three exception outputs at 0.
- R8: A denormal (exponent 0, mantissa nonzero) or a signaling NaN (exponent all ones, mantissa nonzero, mantissa MSB 0) sets `unimpl_o`=1 and `invalid_o`=0, and `result_o` keeps its previous value.
- R9: Infinity, a quiet NaN (mantissa MSB 1), or a finite value whose rounded magnitude falls outside the destination's signed range sets `unimpl_o`=1 and `invalid_o`=1, and `result_o` keeps its previous value.
- R10: The range limits are exact. For a word, 2147483647 and -2147483648 convert, while 2147483648 fails. 2147483647.5 fails under nearest but gives 2147483647 toward zero. For a long, -2^63 converts and 2^63 fails.
- R11: The exception outputs and `result_o` change only in a cycle where `done_o` is 1. Each completion replaces all three exception outputs. Reset clears the result, exceptions and `done_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe that launches a conversion |
| src_dbl_i | input | 1 | Source format: 0 single, 1 double |
| dst_long_i | input | 1 | Destination: 0 word (32-bit), 1 long (64-bit) |
| glob_mode_i | input | 2 | Global rounding mode |
| ovr_valid_i | input | 1 | Per-operation override enable |
| ovr_mode_i | input | 2 | Per-operation override mode |
| operand_i | input | 64 | Floating-point operand bits |
| done_o | output | 1 | Completion pulse |
| result_o | output | 64 | Converted integer (word sign-extended) |
| inexact_o | output | 1 | Fraction bits were discarded |
| invalid_o | output | 1 | Operand or rounded value not representable |
| unimpl_o | output | 1 | Conversion refused; result retained |

## Verification
A wrong captured mode, sign or exponent in the first stage shows up as a wrong `result_o`. A wrong guard or sticky bit shows up as a wrong `inexact_o`. Either error is visible in the same cycle as the `done_o` pulse of that conversion, two edges after its start. A corrupted valid bit in the pipeline shows up as a missing or extra `done_o` pulse, or one at the wrong edge. A bad hold path shows up as the result or exception outputs moving in a cycle without `done_o`, which is visible one cycle after the stray update. The retained-result rule is observed directly: the value from the previous conversion must still be on `result_o` when a refused conversion completes.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
    localparam int SIG_W   = 53;           // hidden bit + widest mantissa
    localparam int FRAC_W  = SIG_W - 1;
    localparam int INT_W   = 64;           // long destination
    localparam int WORD_W  = 32;           // word destination
    localparam int UEXP_W  = 12;           // unbiased exponent, signed
    localparam int SP_EXP  = 8;
    localparam int SP_MAN  = 23;
    localparam int DP_EXP  = 11;
    localparam int DP_MAN  = 52;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_POS  = 2'd2,
        RM_NEG  = 2'd3
    } rmode_e;

    typedef enum logic [2:0] {
        CL_NUM,
        CL_ZERO,
        CL_DENORM,
        CL_SNAN,
        CL_QNAN,
        CL_INF
    } fclass_e;

    typedef struct packed {
        logic                     valid;
        logic                     sign;
        logic signed [UEXP_W-1:0] uexp;
        logic [SIG_W-1:0]         sig;
        fclass_e                  cls;
        rmode_e                   mode;
        logic                     dst_long;
    } stage1_t;

    typedef struct packed {
        logic             done;
        logic [INT_W-1:0] result;
        logic             inexact;
        logic             invalid;
        logic             unimpl;
    } stage2_t;
endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
    import f2i_pkg::*;
#(
    parameter int EXP_BITS = 8,
    parameter int MAN_BITS = 23
) (
    input  logic [EXP_BITS+MAN_BITS:0] bits_i,
    output logic                       sign_o,
    output logic signed [UEXP_W-1:0]   uexp_o,
    output logic [SIG_W-1:0]           sig_o,
    output fclass_e                    cls_o
);
    localparam int BIAS = (1 << (EXP_BITS - 1)) - 1;
    localparam int PAD  = SIG_W - 1 - MAN_BITS;

    logic [EXP_BITS-1:0] exp_f;
    logic [MAN_BITS-1:0] man_f;
    logic [SIG_W-1:0]    sig_raw;

    always_comb begin
        exp_f   = bits_i[EXP_BITS+MAN_BITS-1:MAN_BITS];
        man_f   = bits_i[MAN_BITS-1:0];
        sign_o  = bits_i[EXP_BITS+MAN_BITS];
        sig_raw = SIG_W'({1'b1, man_f});
        sig_o   = sig_raw << PAD;
        uexp_o  = $signed(UEXP_W'(exp_f)) - $signed(UEXP_W'(BIAS));
        cls_o   = CL_NUM;
        if (exp_f == '0) begin
            sig_o  = '0;
            uexp_o = '0;
            cls_o  = (man_f == '0) ? CL_ZERO : CL_DENORM;
        end else if (exp_f == '1) begin
            if (man_f == '0)             cls_o = CL_INF;
            else if (man_f[MAN_BITS-1])  cls_o = CL_QNAN;
            else                         cls_o = CL_SNAN;
        end
    end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
#(
    parameter int OUT_W  = 64,
    parameter int NARROW = 32,
    parameter int SW     = 53
) (
    input  logic                     sign_i,
    input  logic signed [UEXP_W-1:0] uexp_i,
    input  logic [SW-1:0]            sig_i,
    input  rmode_e                   mode_i,
    input  logic                     dst_long_i,
    output logic [OUT_W-1:0]         res_o,
    output logic                     inexact_o,
    output logic                     range_err_o
);
    localparam int FW     = SW - 1;
    localparam int SH_W   = $clog2(OUT_W);
    localparam int WIDE_W = FW + OUT_W;
    localparam int MAG_W  = OUT_W + 1;

    logic [WIDE_W-1:0] wide;
    logic [OUT_W-1:0]  ipart;
    logic              guard, sticky, inc, too_big;
    logic [MAG_W-1:0]  mag, half, limit;

    always_comb begin
        wide    = WIDE_W'(sig_i) << uexp_i[SH_W-1:0];
        too_big = uexp_i > $signed(UEXP_W'(OUT_W - 1));
        if (uexp_i < 0) begin
            ipart  = '0;
            guard  = (uexp_i == -$signed(UEXP_W'(1)));
            sticky = guard ? (|sig_i[FW-1:0]) : 1'b1;
        end else begin
            ipart  = wide[WIDE_W-1:FW];
            guard  = wide[FW-1];
            sticky = |wide[FW-2:0];
        end
        unique case (mode_i)
            RM_NEAR: inc = guard & (sticky | ipart[0]);
            RM_ZERO: inc = 1'b0;
            RM_POS:  inc = ~sign_i & (guard | sticky);
            RM_NEG:  inc = sign_i & (guard | sticky);
            default: inc = 1'b0;
        endcase
        mag         = {1'b0, ipart} + MAG_W'(inc);
        half        = MAG_W'(1) << (dst_long_i ? (OUT_W - 1) : (NARROW - 1));
        limit       = sign_i ? half : (half - MAG_W'(1));
        range_err_o = too_big | (mag > limit);
        inexact_o   = guard | sticky;
        res_o       = sign_i ? (~mag[OUT_W-1:0] + OUT_W'(1)) : mag[OUT_W-1:0];
    end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
    import f2i_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        src_dbl_i,
    input  logic        dst_long_i,
    input  logic [1:0]  glob_mode_i,
    input  logic        ovr_valid_i,
    input  logic [1:0]  ovr_mode_i,
    input  logic [63:0] operand_i,
    output logic        done_o,
    output logic [63:0] result_o,
    output logic        inexact_o,
    output logic        invalid_o,
    output logic        unimpl_o
);
    localparam int SP_W = SP_EXP + SP_MAN + 1;
    localparam int DP_W = DP_EXP + DP_MAN + 1;

    // per-format decoders, one instance per source format
    logic                     fmt_sign [2];
    logic signed [UEXP_W-1:0] fmt_uexp [2];
    logic [SIG_W-1:0]         fmt_sig  [2];
    fclass_e                  fmt_cls  [2];

    for (genvar g = 0; g < 2; g++) begin : g_fmt
        localparam int EB = (g == 0) ? SP_EXP : DP_EXP;
        localparam int MB = (g == 0) ? SP_MAN : DP_MAN;
        f2i_unpack #(.EXP_BITS(EB), .MAN_BITS(MB)) u_unpack (
            .bits_i (operand_i[EB+MB:0]),
            .sign_o (fmt_sign[g]),
            .uexp_o (fmt_uexp[g]),
            .sig_o  (fmt_sig[g]),
            .cls_o  (fmt_cls[g])
        );
    end

    stage1_t s1_d, s1_q;
    stage2_t s2_d, s2_q;

    logic [INT_W-1:0] rnd_res;
    logic             rnd_inexact, rnd_range_err;

    f2i_round #(.OUT_W(INT_W), .NARROW(WORD_W), .SW(SIG_W)) u_round (
        .sign_i      (s1_q.sign),
        .uexp_i      (s1_q.uexp),
        .sig_i       (s1_q.sig),
        .mode_i      (s1_q.mode),
        .dst_long_i  (s1_q.dst_long),
        .res_o       (rnd_res),
        .inexact_o   (rnd_inexact),
        .range_err_o (rnd_range_err)
    );

    always_comb begin
        logic sel;
        logic refuse, bad_val;
        sel   = src_dbl_i;
        s1_d  = s1_q;
        s1_d.valid = start_i;
        if (start_i) begin
            s1_d.sign     = fmt_sign[sel];
            s1_d.uexp     = fmt_uexp[sel];
            s1_d.sig      = fmt_sig[sel];
            s1_d.cls      = fmt_cls[sel];
            s1_d.mode     = rmode_e'(ovr_valid_i ? ovr_mode_i : glob_mode_i);
            s1_d.dst_long = dst_long_i;
        end

        s2_d      = s2_q;
        s2_d.done = s1_q.valid;
        bad_val   = (s1_q.cls == CL_QNAN) || (s1_q.cls == CL_INF) ||
                    ((s1_q.cls == CL_NUM) && rnd_range_err);
        refuse    = bad_val || (s1_q.cls == CL_DENORM) || (s1_q.cls == CL_SNAN);
        if (s1_q.valid) begin
            s2_d.unimpl  = refuse;
            s2_d.invalid = bad_val;
            s2_d.inexact = ~refuse & rnd_inexact;
            if (!refuse) s2_d.result = rnd_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign done_o    = s2_q.done;
    assign result_o  = s2_q.result;
    assign inexact_o = s2_q.inexact;
    assign invalid_o = s2_q.invalid;
    assign unimpl_o  = s2_q.unimpl;
endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        src_dbl_i,
    input logic        dst_long_i,
    input logic [63:0] operand_i,
    input logic        done_o,
    input logic [63:0] result_o,
    input logic        inexact_o,
    input logic        invalid_o,
    input logic        unimpl_o
);
    logic [1:0] cyc_q;
    logic       st1_q, st2_q, z1_q, z2_q, w1_q, w2_q;
    logic       zero_now;

    assign zero_now = src_dbl_i ? ((operand_i & 64'h7FFF_FFFF_FFFF_FFFF) == 64'd0)
                                : ((operand_i & 64'h0000_0000_7FFF_FFFF) == 64'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
            st1_q <= 1'b0; st2_q <= 1'b0;
            z1_q  <= 1'b0; z2_q  <= 1'b0;
            w1_q  <= 1'b0; w2_q  <= 1'b0;
        end else begin
            if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
            st1_q <= start_i;              st2_q <= st1_q;
            z1_q  <= start_i & zero_now;   z2_q  <= z1_q;
            w1_q  <= start_i & ~dst_long_i; w2_q <= w1_q;
        end
    end

    assert_done_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd2) |-> (done_o == st2_q));

    assert_word_signext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && w2_q && !unimpl_o) |-> (result_o[63:32] == {32{result_o[31]}}));

    assert_no_inexact_on_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inexact_o |-> !unimpl_o);

    assert_zero_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && z2_q) |-> (result_o == 64'd0 && !inexact_o && !invalid_o && !unimpl_o));

    // covers R9 as well: any refused conversion keeps the old result
    assert_keep_on_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd1 && done_o && unimpl_o) |-> (result_o == $past(result_o)));

    assert_invalid_subset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> unimpl_o);

    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd1 && !done_o) |->
            ($stable(result_o) && $stable({inexact_o, invalid_o, unimpl_o})));
endmodule

bind f2i_conv f2i_conv_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .src_dbl_i  (src_dbl_i),
    .dst_long_i (dst_long_i),
    .operand_i  (operand_i),
    .done_o     (done_o),
    .result_o   (result_o),
    .inexact_o  (inexact_o),
    .invalid_o  (invalid_o),
    .unimpl_o   (unimpl_o)
);

// File: tb/f2i_conv_bench.sv
`timescale 1ns/1ps
module f2i_conv_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, src_dbl_i = 1'b0, dst_long_i = 1'b0;
    logic [1:0]  glob_mode_i = 2'd0, ovr_mode_i = 2'd0;
    logic        ovr_valid_i = 1'b0;
    logic [63:0] operand_i = 64'd0;
    logic        done_o, inexact_o, invalid_o, unimpl_o;
    logic [63:0] result_o;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    f2i_conv u_f2i_conv (.*);

    // flags packed as {inexact, invalid, unimpl}
    typedef struct packed {
        logic [7:0]  tag;
        logic        sd, dl, ov;
        logic [1:0]  om, gm;
        logic [63:0] op;
        logic        keep;
        logic [63:0] res;
        logic [2:0]  fl;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VECS [NV] = '{
        '{8'd4, 1'b1,1'b0,1'b0,2'd0,2'd1, 64'h4013_9999_9999_999A, 1'b0, 64'd4, 3'b100},                 // R4 4.9 trunc
        '{8'd4, 1'b1,1'b0,1'b0,2'd0,2'd1, 64'hC013_9999_9999_999A, 1'b0, 64'hFFFF_FFFF_FFFF_FFFC, 3'b100}, // R4 -4.9 trunc
        '{8'd4, 1'b1,1'b0,1'b0,2'd0,2'd3, 64'hC013_9999_9999_999A, 1'b0, 64'hFFFF_FFFF_FFFF_FFFB, 3'b100}, // R4 -4.9 floor
        '{8'd4, 1'b1,1'b0,1'b0,2'd0,2'd2, 64'hC010_6666_6666_6666, 1'b0, 64'hFFFF_FFFF_FFFF_FFFC, 3'b100}, // R4 -4.1 ceil
        '{8'd4, 1'b1,1'b0,1'b0,2'd0,2'd2, 64'h4010_6666_6666_6666, 1'b0, 64'd5, 3'b100},                 // R4 4.1 ceil
        '{8'd5, 1'b0,1'b0,1'b0,2'd0,2'd0, 64'h0000_0000_40B0_0000, 1'b0, 64'd6, 3'b100},                 // R5 5.5f tie
        '{8'd5, 1'b1,1'b1,1'b0,2'd0,2'd0, 64'h4004_0000_0000_0000, 1'b0, 64'd2, 3'b100},                 // R5 2.5
        '{8'd5, 1'b1,1'b1,1'b0,2'd0,2'd0, 64'h400C_0000_0000_0000, 1'b0, 64'd4, 3'b100},                 // R5 3.5
        '{8'd5, 1'b1,1'b1,1'b0,2'd0,2'd0, 64'hC004_0000_0000_0000, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 3'b100}, // R5 -2.5
        '{8'd5, 1'b1,1'b0,1'b0,2'd0,2'd0, 64'h4011_9999_9999_999A, 1'b0, 64'd4, 3'b100},                 // R5 4.4
        '{8'd5, 1'b1,1'b0,1'b0,2'd0,2'd0, 64'h4012_6666_6666_6666, 1'b0, 64'd5, 3'b100},                 // R5 4.6
        '{8'd2, 1'b1,1'b0,1'b1,2'd3,2'd2, 64'h4010_6666_6666_6666, 1'b0, 64'd4, 3'b100},                 // R2 override floor
        '{8'd2, 1'b1,1'b0,1'b0,2'd3,2'd2, 64'h4010_6666_6666_6666, 1'b0, 64'd5, 3'b100},                 // R2 override off
        '{8'd6, 1'b1,1'b0,1'b0,2'd0,2'd0, 64'h4018_0000_0000_0000, 1'b0, 64'd6, 3'b000},                 // R6 exact 6.0
        '{8'd7, 1'b1,1'b0,1'b0,2'd0,2'd0, 64'h0000_0000_0000_0000, 1'b0, 64'd0, 3'b000},                 // R7 +0
        '{8'd7, 1'b1,1'b0,1'b0,2'd0,2'd3, 64'h8000_0000_0000_0000, 1'b0, 64'd0, 3'b000},                 // R7 -0
        '{8'd8, 1'b1,1'b0,1'b0,2'd0,2'd1, 64'h0000_0000_0000_0001, 1'b1, 64'd0, 3'b001},                 // R8 denormal
        '{8'd8, 1'b1,1'b0,1'b0,2'd0,2'd1, 64'h7FF4_0000_0000_0000, 1'b1, 64'd0, 3'b001},                 // R8 sNaN
        '{8'd8, 1'b0,1'b0,1'b0,2'd0,2'd1, 64'h0000_0000_7FA0_0000, 1'b1, 64'd0, 3'b001},                 // R8 sNaN single
        '{8'd9, 1'b1,1'b0,1'b0,2'd0,2'd1, 64'h7FF0_0000_0000_0000, 1'b1, 64'd0, 3'b011},                 // R9 +inf
        '{8'd9, 1'b1,1'b0,1'b0,2'd0,2'd1, 64'h7FF8_0000_0000_0000, 1'b1, 64'd0, 3'b011},                 // R9 qNaN
        '{8'd9, 1'b0,1'b1,1'b0,2'd0,2'd1, 64'h0000_0000_FF80_0000, 1'b1, 64'd0, 3'b011},                 // R9 -inf single
        '{8'd10,1'b1,1'b0,1'b0,2'd0,2'd1, 64'h41DF_FFFF_FFC0_0000, 1'b0, 64'h0000_0000_7FFF_FFFF, 3'b000}, // R10 word max
        '{8'd10,1'b1,1'b0,1'b0,2'd0,2'd1, 64'h41E0_0000_0000_0000, 1'b1, 64'd0, 3'b011},                 // R10 2^31
        '{8'd10,1'b1,1'b0,1'b0,2'd0,2'd1, 64'hC1E0_0000_0000_0000, 1'b0, 64'hFFFF_FFFF_8000_0000, 3'b000}, // R10 -2^31
        '{8'd10,1'b1,1'b0,1'b0,2'd0,2'd0, 64'h41DF_FFFF_FFE0_0000, 1'b1, 64'd0, 3'b011},                 // R10 tie up out
        '{8'd10,1'b1,1'b0,1'b0,2'd0,2'd1, 64'h41DF_FFFF_FFE0_0000, 1'b0, 64'h0000_0000_7FFF_FFFF, 3'b100}, // R10 trunc in
        '{8'd10,1'b1,1'b1,1'b0,2'd0,2'd1, 64'hC3E0_0000_0000_0000, 1'b0, 64'h8000_0000_0000_0000, 3'b000}, // R10 -2^63
        '{8'd10,1'b1,1'b1,1'b0,2'd0,2'd1, 64'h43E0_0000_0000_0000, 1'b1, 64'd0, 3'b011},                 // R10 2^63
        '{8'd3, 1'b0,1'b1,1'b0,2'd0,2'd1, 64'h0000_0000_5380_0000, 1'b0, 64'h0000_0100_0000_0000, 3'b000}, // R3 2^40f long
        '{8'd3, 1'b0,1'b0,1'b0,2'd0,2'd1, 64'h0000_0000_5380_0000, 1'b1, 64'd0, 3'b011},                 // R3 2^40f word
        '{8'd3, 1'b0,1'b0,1'b0,2'd0,2'd1, 64'hDEAD_BEEF_40B0_0000, 1'b0, 64'd5, 3'b100},                 // R3 upper ignored
        '{8'd4, 1'b0,1'b0,1'b0,2'd0,2'd2, 64'h0000_0000_3E99_999A, 1'b0, 64'd1, 3'b100},                 // R4 0.3 ceil
        '{8'd5, 1'b0,1'b0,1'b0,2'd0,2'd0, 64'h0000_0000_3E99_999A, 1'b0, 64'd0, 3'b100},                 // R5 0.3 nearest
        '{8'd4, 1'b0,1'b0,1'b0,2'd0,2'd2, 64'h0000_0000_BE99_999A, 1'b0, 64'd0, 3'b100},                 // R4 -0.3 ceil
        '{8'd4, 1'b0,1'b0,1'b0,2'd0,2'd3, 64'h0000_0000_BE99_999A, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 3'b100}, // R4 -0.3 floor
        '{8'd8, 1'b0,1'b0,1'b0,2'd0,2'd1, 64'h0000_0000_0000_0001, 1'b1, 64'd0, 3'b001}                  // R8 single denormal
    };

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        src_dbl_i   = v.sd;  dst_long_i = v.dl;
        ovr_valid_i = v.ov;  ovr_mode_i = v.om;
        glob_mode_i = v.gm;  operand_i  = v.op;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog act=hung exp=complete");
        finish_run();
    end

    initial begin
        logic [63:0] prev_res;
        logic [2:0]  prev_fl;
        repeat (3) @(negedge clk);
        // reset state R11
        chk("R11", "reset done", {63'd0, done_o}, 64'd0);
        chk("R11", "reset result", result_o, 64'd0);
        chk("R11", "reset flags", {61'd0, inexact_o, invalid_o, unimpl_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        prev_res = 64'd0;

        for (int i = 0; i < NV; i++) begin
            vec_t  v;
            string tg;
            logic [63:0] er;
            v  = VECS[i];
            tg = $sformatf("R%0d", v.tag);
            drive(v);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            operand_i = ~v.op;  // must not affect the running conversion
            chk("R1", "done early", {63'd0, done_o}, 64'd0);
            @(negedge clk);
            chk("R1", "done pulse", {63'd0, done_o}, 64'd1);
            er = v.keep ? prev_res : v.res;
            chk(tg, $sformatf("vec%0d result", i), result_o, er);
            chk(tg, $sformatf("vec%0d flags", i), {61'd0, inexact_o, invalid_o, unimpl_o}, {61'd0, v.fl});
            prev_res = er;
            @(negedge clk);
            chk("R1", "done width", {63'd0, done_o}, 64'd0);
        end

        // R11: outputs hold while idle, even with inputs moving
        prev_fl = {inexact_o, invalid_o, unimpl_o};
        drive(VECS[0]);
        operand_i = 64'h4018_0000_0000_0000;
        repeat (5) @(negedge clk);
        chk("R11", "idle result", result_o, prev_res);
        chk("R11", "idle flags", {61'd0, inexact_o, invalid_o, unimpl_o}, {61'd0, prev_fl});

        // R1: back-to-back starts, 4.9 trunc then 6.0 trunc
        drive(VECS[0]);
        start_i = 1'b1;
        @(negedge clk);
        operand_i = 64'h4018_0000_0000_0000;
        @(negedge clk);
        start_i = 1'b0;
        chk("R1", "b2b first done", {63'd0, done_o}, 64'd1);
        chk("R1", "b2b first result", result_o, 64'd4);
        chk("R6", "b2b first inexact", {63'd0, inexact_o}, 64'd1);
        @(negedge clk);
        chk("R1", "b2b second done", {63'd0, done_o}, 64'd1);
        chk("R1", "b2b second result", result_o, 64'd6);
        chk("R11", "b2b flags replaced", {61'd0, inexact_o, invalid_o, unimpl_o}, 64'd0);
        @(negedge clk);
        chk("R1", "b2b ends", {63'd0, done_o}, 64'd0);

        // R2: override nearest wins over global ceil on 4.4
        drive(VECS[0]);
        operand_i = 64'h4011_9999_9999_999A;
        glob_mode_i = 2'd2; ovr_valid_i = 1'b1; ovr_mode_i = 2'd0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        chk("R2", "override nearest", result_o, 64'd4);

        finish_run();
    end
endmodule